// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is one timer channel behind a small word-indexed register bus. A counter steps down once per prescaled tick, where a tick is a cycle with `tick_en` high, divided by 1, 16 or 256. Software selects one of three behaviours:

- **Free-running:** the counter wraps to its all-ones value and ignores the stored load.
- **Periodic:** the counter reloads the stored load value after it reaches zero.
- **One-shot:** the counter parks at zero after it expires once.

The counter width is either 16 or 32 bits.

Each expiry sets a sticky raw flag. The interrupt line is that flag gated by an enable bit. Two registers give the stored load value. Writing the foreground one reloads the counter at once. Writing the background one changes only the value used at the next reload.

Reads are combinational: `rd_data` reflects `req_addr` in the same cycle. Writes take effect at the clock edge where `req_wr` is high.

Top module: `countdown_timer`

## Requirements
- R1: The control word holds `single` (bit 0), `wide` (bit 1), prescale select (bits 3:2), `irq_en` (bit 5), `periodic` (bit 6) and `run` (bit 7). Bit 4 and bits above 7 read 0. After reset the control word reads 0x20.
- R2: When `wide` is 1 the counter is 32 bits wide; when `wide` is 0 it is 16 bits wide.
- R3: The counter steps only on cycles with `tick_en` high, and only while `run` is 1. Prescale select 01 takes 16 such cycles per step and 10 takes 256. Both 00 and 11 take one.
- R4: With `single` and `periodic` both 0, the counter is free-running. It wraps from zero to 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit). In 16-bit size, bits 31:16 of the current value read 0.
- R5: A write to index 0 stores the load value and reloads the counter at once. The reload value is the load value, or the all-ones value when free-running.
- R6: A write to index 6 stores the load value without touching the running count. Index 6 reads back the stored load value.
- R7: A step from 1 to 0 sets the raw flag, read at index 4. The flag holds until index 3 is written. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq` and the masked status at index 5 both equal the raw flag ANDed with `irq_en`.
- R9: A control write with `run` = 1 reloads the counter and restarts the prescaler. A control write with `run` = 0 freezes the count.
- R10: With `single` = 1 (even when `periodic` is also 1), the counter stays at zero after its expiry until it is reprogrammed.
- R11: Index 1 reads the current value. Writes to index 1 are ignored.
- R12: Indices 3 and 7 read 0. A write to index 7 changes nothing.
- R13: In periodic mode, a step taken at zero reloads the stored load value, so a full period is load+1 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer tick qualifier, one per counting cycle |
| req_wr | input | 1 | Write strobe for the indexed register |
| req_addr | input | ADDR_W (3) | Word register index |
| req_wdata | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data for `req_addr`, combinational |
| irq | output | 1 | Level interrupt, raw flag gated by `irq_en` |

## Verification
The properties assume that `req_addr` and `req_wr` are steady and known across each clock edge. They also assume that a write and a step are related only through the documented priority: a write wins over a step. The bench changes every input on the falling edge and only through one task. Reads that need no clock are made in mid-cycle with `req_wr` low, so a check never coincides with a write the properties would have to excuse. The bench also drives `tick_en` low for long stretches, which exercises the freeze properties while a step is blocked.

// File: rtl/countdown_timer_pkg.sv
// Shared definitions for the interval timer: register indices and the
// control word layout. Assumes an 8-bit control field in the low byte.
package countdown_timer_pkg;

    typedef enum logic [2:0] {
        IDX_LOAD   = 3'd0,
        IDX_VALUE  = 3'd1,
        IDX_CTRL   = 3'd2,
        IDX_ICLR   = 3'd3,
        IDX_RAW    = 3'd4,
        IDX_MASKED = 3'd5,
        IDX_BGLOAD = 3'd6,
        IDX_SPARE  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       irq_en;
        logic       rsvd;
        logic [1:0] prescale;
        logic       wide;
        logic       single;
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h20;
    localparam logic [7:0] CTRL_KEEP  = 8'hEF;

endpackage

// File: rtl/cdt_prescaler.sv
// Tick divider: emits one step for every 1, 16 or 256 qualified ticks.
// Assumes PRE_W >= 8. The phase restarts on a control write and while idle.
module cdt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic       tick_en,
    input  logic [1:0] sel,
    output logic       step
);
    localparam logic [PRE_W-1:0] LIM_1   = '0;
    localparam logic [PRE_W-1:0] LIM_16  = PRE_W'(15);
    localparam logic [PRE_W-1:0] LIM_256 = PRE_W'(255);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit;

    // Terminal phase for the selected division ratio
    always_comb begin
        case (sel)
            2'b01:   limit = LIM_16;
            2'b10:   limit = LIM_256;
            default: limit = LIM_1;
        endcase
    end

    // Phase counter advancing on qualified ticks
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            phase_q <= '0;
        end else if (tick_en) begin
            phase_q <= (phase_q == limit) ? '0 : phase_q + 1'b1;
        end
    end

    assign step = run && tick_en && !restart && (phase_q == limit);

endmodule

// File: rtl/cdt_counter.sv
// Down counter with mode-dependent reload. A reload request outranks a step.
// Assumes CNT_W >= SHORT_W. The stored count is always written pre-masked.
module cdt_counter #(
    parameter int CNT_W   = 32,
    parameter int SHORT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    input  logic             single,
    input  logic             periodic,
    input  logic             wide,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] MASK_SHORT = {{(CNT_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
    localparam logic [CNT_W-1:0] MASK_WIDE  = '1;
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] target;

    // Size mask, visible value and reload target
    always_comb begin
        mask   = wide ? MASK_WIDE : MASK_SHORT;
        cur    = cnt_q & mask;
        target = (!single && !periodic) ? mask : (load_val & mask);
    end

    // Count register: reload, wrap/park at zero, or decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= target;
        end else if (step) begin
            if (cur == '0) begin
                if (!single) cnt_q <= target;
            end else begin
                cnt_q <= cur - ONE;
            end
        end
    end

    assign count  = cur;
    assign expire = step && !reload && (cur == ONE);

endmodule

// File: rtl/countdown_timer.sv
// Single timer channel: register decode, control/load storage, sticky raw
// flag and interrupt gating. Assumes a 3-bit word index and DATA_W >= 16.
module countdown_timer
    import countdown_timer_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32,
    parameter int SHORT_W = 16,
    parameter int PRE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    ctrl_t             ctrl_q, ctrl_eff;
    logic [DATA_W-1:0] load_q, load_eff;
    logic              raw_q;
    logic              wr_load, wr_bg, wr_ctrl, wr_clr;
    logic              step, reload, expire;
    logic [DATA_W-1:0] count_now;

    // Write decode per register index
    always_comb begin
        wr_load = req_wr && (req_addr == ADDR_W'(IDX_LOAD));
        wr_bg   = req_wr && (req_addr == ADDR_W'(IDX_BGLOAD));
        wr_ctrl = req_wr && (req_addr == ADDR_W'(IDX_CTRL));
        wr_clr  = req_wr && (req_addr == ADDR_W'(IDX_ICLR));
    end

    // Values in force this cycle, so a reload sees the data being written
    always_comb begin
        ctrl_eff = wr_ctrl ? ctrl_t'(req_wdata[7:0] & CTRL_KEEP) : ctrl_q;
        load_eff = (wr_load || wr_bg) ? req_wdata : load_q;
        reload   = wr_load || (wr_ctrl && req_wdata[7]);
    end

    // Control and load storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= ctrl_t'(CTRL_RESET);
            load_q <= '0;
        end else begin
            ctrl_q <= ctrl_eff;
            load_q <= load_eff;
        end
    end

    // Sticky raw flag; a new expiry outranks a clear
    always_ff @(posedge clk) begin
        if (!rst_n)      raw_q <= 1'b0;
        else if (expire) raw_q <= 1'b1;
        else if (wr_clr) raw_q <= 1'b0;
    end

    cdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_ctrl),
        .run     (ctrl_q.run),
        .tick_en (tick_en),
        .sel     (ctrl_q.prescale),
        .step    (step)
    );

    cdt_counter #(.CNT_W(DATA_W), .SHORT_W(SHORT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .reload   (reload),
        .load_val (load_eff),
        .single   (ctrl_eff.single),
        .periodic (ctrl_eff.periodic),
        .wide     (ctrl_eff.wide),
        .count    (count_now),
        .expire   (expire)
    );

    // Read multiplexer; unmapped indices return zero
    always_comb begin
        rd_data = '0;
        case (req_addr)
            ADDR_W'(IDX_LOAD),
            ADDR_W'(IDX_BGLOAD): rd_data = load_q;
            ADDR_W'(IDX_VALUE):  rd_data = count_now;
            ADDR_W'(IDX_CTRL):   rd_data = DATA_W'(ctrl_q);
            ADDR_W'(IDX_RAW):    rd_data = DATA_W'(raw_q);
            ADDR_W'(IDX_MASKED): rd_data = DATA_W'(raw_q && ctrl_q.irq_en);
            default:             rd_data = '0;
        endcase
    end

    assign irq = raw_q && ctrl_q.irq_en;

endmodule

// File: rtl/countdown_timer_chk.sv
// Property checker for countdown_timer, attached by bind below.
// Assumes inputs are steady across each rising clock edge.
module countdown_timer_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_wr,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq,
    input logic              raw_flag,
    input logic [7:0]        ctrl_bits,
    input logic [DATA_W-1:0] count_now
);
    // R7
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_flag && !(req_wr && req_addr == ADDR_W'(3))) |=> raw_flag);

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[7] && !(req_wr && (req_addr == ADDR_W'(0) || req_addr == ADDR_W'(2))))
        |=> $stable(count_now));

    // R10
    oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bits[7] && ctrl_bits[0] && count_now == '0 && !req_wr) |=> (count_now == '0));

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[1] && req_addr == ADDR_W'(1)) |-> (rd_data[DATA_W-1:16] == '0));

    // R8
    masked_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr == ADDR_W'(5)) |-> (rd_data[0] == irq));

    // R12
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr == ADDR_W'(7)) |-> (rd_data == '0));

    // R11
    value_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_addr == ADDR_W'(1) && !ctrl_bits[7]) |=> $stable(count_now));

endmodule

bind countdown_timer countdown_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_wr    (req_wr),
    .req_addr  (req_addr),
    .rd_data   (rd_data),
    .irq       (irq),
    .raw_flag  (raw_q),
    .ctrl_bits (ctrl_q),
    .count_now (count_now)
);

// File: tb/countdown_timer_test.sv
module countdown_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        req_wr = 1'b0;
    logic [2:0]  req_addr = 3'd0;
    logic [31:0] req_wdata = 32'd0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_ctrl, m_load, m_cnt, m_pcnt;
    logic        m_raw;

    always #10 clk = ~clk;

    countdown_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .irq(irq)
    );

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        logic wl, wc, wb, wk, stp, hit;
        logic [31:0] nc, nl, mask, tgt, cur;
        int div;
        if (!rst_n) begin
            m_ctrl = 32'h20; m_load = 0; m_cnt = 0; m_raw = 0; m_pcnt = 0;
        end else begin
            wl = req_wr && req_addr == 0; wc = req_wr && req_addr == 2;
            wb = req_wr && req_addr == 6; wk = req_wr && req_addr == 3;
            nc = wc ? (req_wdata & 32'hEF) : m_ctrl;
            nl = (wl || wb) ? req_wdata : m_load;
            div = (m_ctrl[3:2] == 2'b01) ? 16 : (m_ctrl[3:2] == 2'b10) ? 256 : 1;
            stp = 0; hit = 0;
            if (wc || !m_ctrl[7]) m_pcnt = 0;
            else if (tick_en) begin
                if (m_pcnt == div - 1) begin stp = 1; m_pcnt = 0; end
                else m_pcnt = m_pcnt + 1;
            end
            mask = nc[1] ? 32'hFFFFFFFF : 32'h0000FFFF;
            tgt = (!nc[0] && !nc[6]) ? mask : (nl & mask);
            cur = m_cnt & mask;
            if (wl || (wc && nc[7])) m_cnt = tgt;
            else if (stp) begin
                if (cur == 0) begin
                    if (!nc[0]) m_cnt = tgt;
                end else begin
                    m_cnt = cur - 1; hit = (cur == 1);
                end
            end
            if (hit) m_raw = 1; else if (wk) m_raw = 0;
            m_ctrl = nc; m_load = nl;
        end
    end

    function automatic logic [31:0] model_read(input logic [2:0] a);
        logic [31:0] mask;
        mask = m_ctrl[1] ? 32'hFFFFFFFF : 32'h0000FFFF;
        case (a)
            3'd0, 3'd6: return m_load;
            3'd1: return m_cnt & mask;
            3'd2: return m_ctrl;
            3'd4: return {31'd0, m_raw};
            3'd5: return {31'd0, m_raw & m_ctrl[5]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0, 3'd6: return "R6";
            3'd1: return "R11";
            3'd2: return "R1";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive on the falling edge, compare against the model after the rise
    task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d);
        req_wr = w; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        if (rst_n) begin
            check(tag_of(a), rd_data, model_read(a));
            check("R8", {31'd0, irq}, {31'd0, m_raw & m_ctrl[5]});
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'(1 + (i % 5)), 32'd0);
    endtask

    // mid-cycle read against a value derived from the requirements
    task automatic chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        req_wr = 0; req_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
        rst_n = 1;
        // R1 reset state
        chk(2, 32'h20, "R1"); chk(1, 0, "R11"); chk(0, 0, "R5");
        check("R8", {31'd0, irq}, 32'd0);
        // R5/R13 periodic operation
        cyc(1, 2, 32'h60);
        cyc(1, 0, 32'd3);
        chk(1, 3, "R5");
        cyc(1, 2, 32'hE0);
        chk(1, 3, "R9");
        idle(3);
        chk(1, 0, "R13"); chk(4, 1, "R7");
        check("R8", {31'd0, irq}, 32'd1);
        idle(1);
        chk(1, 3, "R13"); chk(4, 1, "R7");
        // R7 clear
        cyc(1, 3, 32'd0);
        chk(4, 0, "R7"); chk(1, 2, "R13");
        // R6 background load
        cyc(1, 6, 32'd10);
        chk(1, 1, "R6"); chk(0, 10, "R6");
        idle(1);
        chk(4, 1, "R7");
        idle(1);
        chk(1, 10, "R6");
        // R8 masking
        cyc(1, 2, 32'hC0);
        chk(5, 0, "R8"); chk(4, 1, "R8");
        check("R8", {31'd0, irq}, 32'd0);
        // R9 freeze, R11 ignored write, R12 unmapped
        cyc(1, 2, 32'h40);
        idle(5);
        chk(1, 10, "R9");
        cyc(1, 1, 32'h1234);
        chk(1, 10, "R11");
        chk(7, 0, "R12"); chk(3, 0, "R12");
        // R10 one-shot with periodic also set
        cyc(1, 3, 0);
        cyc(1, 0, 32'd2);
        cyc(1, 2, 32'hE1);
        idle(2);
        chk(1, 0, "R10"); chk(4, 1, "R10");
        idle(5);
        chk(1, 0, "R10");
        // R4 free-running 16-bit wrap
        cyc(1, 3, 0);
        cyc(1, 2, 32'hA0);
        chk(1, 32'hFFFF, "R4");
        idle(1);
        chk(1, 32'hFFFE, "R4");
        idle(65534);
        chk(1, 0, "R4"); chk(4, 1, "R4");
        idle(1);
        chk(1, 32'hFFFF, "R4");
        // R2 32-bit size
        cyc(1, 2, 32'hA2);
        chk(1, 32'hFFFFFFFF, "R2");
        idle(1);
        chk(1, 32'hFFFFFFFE, "R2");
        cyc(1, 2, 32'h20);
        chk(1, 32'h0000FFFE, "R2");
        // R3 prescaler /16, tick gating, /256, select 11
        cyc(1, 3, 0);
        cyc(1, 2, 32'h40);
        cyc(1, 0, 32'd5);
        cyc(1, 2, 32'hC4);
        idle(15);
        chk(1, 5, "R3");
        idle(1);
        chk(1, 4, "R3");
        tick_en = 0;
        idle(40);
        chk(1, 4, "R3");
        tick_en = 1;
        cyc(1, 2, 32'hC8);
        idle(255);
        chk(1, 5, "R3");
        idle(1);
        chk(1, 4, "R3");
        cyc(1, 2, 32'hCC);
        idle(1);
        chk(1, 4, "R3"); chk(2, 32'hCC, "R1");
        // R1 reserved bit, R12 spare write
        cyc(1, 2, 32'hFFFF_FF1F);
        chk(2, 32'h0F, "R1");
        cyc(1, 7, 32'hFFFFFFFF);
        chk(2, 32'h0F, "R12"); chk(0, 5, "R12");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule